// File: doc/BRIEF.md
# Weighted Multi-Neighbor PI Loop Filter

This block is the digital loop filter of one node in a mesh of coupled oscillators. Up to four neighbor phase comparators each hand it a small signed phase error. Each error is scaled by its own programmable link weight, and the scaled errors are summed. The sum feeds two paths: a proportional path and an integrating path. Each path has a fractional gain, written as an integer numerator over a power of two. The two results are added to form an unsigned frequency control word for the local oscillator. The filter runs on the local oscillator clock divided by four.

A mode input sets how the mesh is coupled. In startup mode only the upper and left links take part, so phase information flows in one direction from the root node and no cyclic lock state can form. In coupled mode all programmed weights apply. A link whose weight is zero is disconnected in either mode, which is how edge and corner nodes with fewer neighbors are configured.

The integrating path keeps a fixed-point accumulator. Its integer part has as many bits as the control word, and below that it carries as many fraction bits as the integral shift. Only the rounded integer part reaches the output. The accumulator and the control word both clamp at their limits instead of wrapping. Reset puts the accumulator and the control word at a programmable mid-range code.

Top module: `mesh_pi_filter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ctrl_word` is loaded with `mid_code` and the accumulator with `mid_code` times 2^KI_SH. With no further drive, the first cycle after reset therefore shows `mid_code`.
- R2: The error sum is the sum over active links of err_i × w_i. err_i is the 5-bit two's-complement field `err_vec[5i+4:5i]`, and w_i is the unsigned 4-bit field `wgt_vec[4i+3:4i]`. A link with w_i = 0 has no effect, whatever its error.
- R3: When `coupled_en` = 0 (startup), links 2 (lower) and 3 (right) are ignored. Only links 0 (upper) and 1 (left) contribute.
- R4: When `coupled_en` = 1, all four links contribute with their programmed weights.
- R5: The proportional term is floor((S × kprop + 2^(KP_SH−1)) / 2^KP_SH), where S is the error sum. This is round-half-up, applied to signed values.
- R6: At each clock edge out of reset, the accumulator adds S × kint, in units of 2^−KI_SH.
- R7: At each edge, `ctrl_word` is registered as the round-half-up integer part of the updated accumulator plus the proportional term of the errors presented before that edge. The latency is one cycle.
- R8: The accumulator clamps to the range 0 to 2^(NDCO+KI_SH)−1 and never wraps. A step in the opposite direction leaves a clamped limit at once.
- R9: `ctrl_word` clamps to the range 0 to 2^NDCO−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided oscillator clock (oscillator / 4) |
| rst_n | input | 1 | Synchronous active-low reset |
| coupled_en | input | 1 | 0 = startup (upper and left links only), 1 = all links |
| err_vec | input | NLINK*ERR_W | Packed signed errors; link 0 upper, 1 left, 2 lower, 3 right |
| wgt_vec | input | NLINK*WGT_W | Packed unsigned per-link weights |
| kprop | input | KP_W | Proportional gain numerator |
| kint | input | KI_W | Integral gain numerator |
| mid_code | input | NDCO | Control word loaded at reset |
| ctrl_word | output | NDCO | Registered oscillator frequency control word |

## Verification
The assertions assume that gains, weights and the mode are quasi-static. A hold check expects `kprop` and `kint` to stay at zero over consecutive cycles before the control word is required to stay still. The assertions also assume that `mid_code` is steady across the release of reset. The stimulus changes inputs only between active edges. It holds `mid_code` fixed for the whole run. It applies errors across the full signed 5-bit range, so the saturation checks are reached through real accumulator growth and not by forcing state.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

    // link roles by index; forward links carry information away from the root
    localparam int LINK_UPPER = 0;
    localparam int LINK_LEFT  = 1;
    localparam int LINK_LOWER = 2;
    localparam int LINK_RIGHT = 3;

    typedef enum logic {
        MODE_STARTUP = 1'b0,
        MODE_COUPLED = 1'b1
    } mesh_mode_e;

    // a link is live during startup only if it comes from above or from the left
    function automatic bit link_live_in_startup(input int idx);
        return (idx == LINK_UPPER) || (idx == LINK_LEFT);
    endfunction

endpackage

// File: rtl/mpf_link_term.sv
module mpf_link_term #(
    parameter int ERR_W   = 5,
    parameter int WGT_W   = 4,
    parameter bit FORWARD = 1'b1,
    localparam int PROD_W = ERR_W + WGT_W + 1
) (
    input  logic                     coupled_en,
    input  logic signed [ERR_W-1:0]  err,
    input  logic        [WGT_W-1:0]  wgt,
    output logic signed [PROD_W-1:0] prod
);
    import mpf_pkg::*;

    logic link_on;

    // R3/R4: reverse links are gated off until the mesh is coupled
    always_comb begin
        link_on = FORWARD || (mesh_mode_e'(coupled_en) == MODE_COUPLED);
        if (link_on) begin
            prod = err * $signed({1'b0, wgt});
        end else begin
            prod = '0;
        end
    end

endmodule

// File: rtl/mpf_prop_path.sv
module mpf_prop_path #(
    parameter int SUM_W = 12,
    parameter int KP_W  = 6,
    parameter int KP_SH = 2,
    localparam int PROP_W = SUM_W + KP_W + 1
) (
    input  logic signed [SUM_W-1:0] wsum,
    input  logic        [KP_W-1:0]  kprop,
    output logic signed [PROP_W:0]  prop_rnd
);
    localparam logic signed [PROP_W:0] HALF_P =
        (KP_SH > 0) ? ((PROP_W+1)'(1) << (KP_SH - 1)) : '0;

    logic signed [PROP_W-1:0] prod;
    logic signed [PROP_W:0]   biased;

    // R5: round half up on the shifted product
    always_comb begin
        prod     = wsum * $signed({1'b0, kprop});
        biased   = {prod[PROP_W-1], prod} + HALF_P;
        prop_rnd = biased >>> KP_SH;
    end

endmodule

// File: rtl/mpf_int_path.sv
module mpf_int_path #(
    parameter int SUM_W = 12,
    parameter int KI_W  = 6,
    parameter int KI_SH = 6,
    parameter int NDCO  = 10,
    localparam int NACC   = NDCO + KI_SH,
    localparam int STEP_W = SUM_W + KI_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [SUM_W-1:0]  wsum,
    input  logic        [KI_W-1:0]   kint,
    input  logic        [NDCO-1:0]   mid_code,
    output logic signed [STEP_W-1:0] int_step,
    output logic        [NACC-1:0]   acc_q,
    output logic        [NDCO:0]     acc_round
);
    localparam int WW = ((NACC > STEP_W) ? NACC : STEP_W) + 2;
    localparam logic signed [WW-1:0] ACC_MAX = {{(WW-NACC){1'b0}}, {NACC{1'b1}}};
    localparam logic [NACC:0] HALF_I =
        (KI_SH > 0) ? ((NACC+1)'(1) << (KI_SH - 1)) : '0;

    typedef struct packed {
        logic [NACC-1:0] acc;
    } int_state_t;

    int_state_t st_d;
    logic signed [WW-1:0] acc_x;
    logic signed [WW-1:0] step_x;
    logic signed [WW-1:0] sum_x;
    logic        [NACC:0] biased;
    logic        [NACC:0] shifted;

    always_comb begin
        int_step = wsum * $signed({1'b0, kint});           // R6
        acc_x    = $signed({{(WW-NACC){1'b0}}, acc_q});
        step_x   = {{(WW-STEP_W){int_step[STEP_W-1]}}, int_step};
        sum_x    = acc_x + step_x;
        // R8: clamp instead of wrap
        if (sum_x < 0) begin
            st_d.acc = '0;
        end else if (sum_x > ACC_MAX) begin
            st_d.acc = ACC_MAX[NACC-1:0];
        end else begin
            st_d.acc = sum_x[NACC-1:0];
        end
        biased    = {1'b0, st_d.acc} + HALF_I;
        shifted   = biased >> KI_SH;
        acc_round = shifted[NDCO:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= NACC'(mid_code) << KI_SH;              // R1
        end else begin
            acc_q <= st_d.acc;
        end
    end

endmodule

// File: rtl/mesh_pi_filter.sv
module mesh_pi_filter #(
    parameter int NLINK = 4,
    parameter int ERR_W = 5,
    parameter int WGT_W = 4,
    parameter int NDCO  = 10,
    parameter int KP_W  = 6,
    parameter int KP_SH = 2,
    parameter int KI_W  = 6,
    parameter int KI_SH = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   coupled_en,
    input  logic [NLINK*ERR_W-1:0] err_vec,
    input  logic [NLINK*WGT_W-1:0] wgt_vec,
    input  logic [KP_W-1:0]        kprop,
    input  logic [KI_W-1:0]        kint,
    input  logic [NDCO-1:0]        mid_code,
    output logic [NDCO-1:0]        ctrl_word
);
    localparam int PROD_W = ERR_W + WGT_W + 1;
    localparam int SUM_W  = PROD_W + $clog2(NLINK);
    localparam int PROP_W = SUM_W + KP_W + 1;
    localparam int NACC   = NDCO + KI_SH;
    localparam int STEP_W = SUM_W + KI_W + 1;
    localparam int OW     = (((NDCO + 2) > (PROP_W + 1)) ? (NDCO + 2) : (PROP_W + 1)) + 1;
    localparam logic signed [OW-1:0] CTRL_MAX = {{(OW-NDCO){1'b0}}, {NDCO{1'b1}}};

    typedef struct packed {
        logic [NDCO-1:0] ctrl;
    } out_state_t;

    logic signed [PROD_W-1:0] link_prod [NLINK];
    logic signed [SUM_W-1:0]  wsum;
    logic signed [PROP_W:0]   prop_rnd;
    logic signed [STEP_W-1:0] int_step;
    logic        [NACC-1:0]   acc_q;
    logic        [NDCO:0]     acc_round;
    logic signed [OW-1:0]     total;
    out_state_t               out_d;
    out_state_t               out_q;

    // R2: one weighted term per neighbor link
    for (genvar g = 0; g < NLINK; g++) begin : g_link
        mpf_link_term #(
            .ERR_W  (ERR_W),
            .WGT_W  (WGT_W),
            .FORWARD(mpf_pkg::link_live_in_startup(g))
        ) u_term (
            .coupled_en(coupled_en),
            .err       ($signed(err_vec[g*ERR_W +: ERR_W])),
            .wgt       (wgt_vec[g*WGT_W +: WGT_W]),
            .prod      (link_prod[g])
        );
    end

    always_comb begin
        wsum = '0;
        for (int i = 0; i < NLINK; i++) begin
            wsum = wsum + {{(SUM_W-PROD_W){link_prod[i][PROD_W-1]}}, link_prod[i]};
        end
    end

    mpf_prop_path #(
        .SUM_W(SUM_W),
        .KP_W (KP_W),
        .KP_SH(KP_SH)
    ) u_prop (
        .wsum    (wsum),
        .kprop   (kprop),
        .prop_rnd(prop_rnd)
    );

    mpf_int_path #(
        .SUM_W(SUM_W),
        .KI_W (KI_W),
        .KI_SH(KI_SH),
        .NDCO (NDCO)
    ) u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .wsum     (wsum),
        .kint     (kint),
        .mid_code (mid_code),
        .int_step (int_step),
        .acc_q    (acc_q),
        .acc_round(acc_round)
    );

    // R7/R9: combine paths and clamp to the control-word range
    always_comb begin
        total = {{(OW-PROP_W-1){prop_rnd[PROP_W]}}, prop_rnd}
              + $signed({{(OW-NDCO-1){1'b0}}, acc_round});
        if (total < 0) begin
            out_d.ctrl = '0;
        end else if (total > CTRL_MAX) begin
            out_d.ctrl = CTRL_MAX[NDCO-1:0];
        end else begin
            out_d.ctrl = total[NDCO-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.ctrl <= mid_code;                         // R1
        end else begin
            out_q <= out_d;
        end
    end

    assign ctrl_word = out_q.ctrl;

endmodule

// File: rtl/mpf_filter_chk.sv
module mpf_filter_chk #(
    parameter int NLINK  = 4,
    parameter int ERR_W  = 5,
    parameter int WGT_W  = 4,
    parameter int NDCO   = 10,
    parameter int KP_W   = 6,
    parameter int KI_W   = 6,
    parameter int SUM_W  = 12,
    parameter int NACC   = 16,
    parameter int STEP_W = 19
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     coupled_en,
    input logic [NLINK*ERR_W-1:0]   err_vec,
    input logic [NLINK*WGT_W-1:0]   wgt_vec,
    input logic [KP_W-1:0]          kprop,
    input logic [KI_W-1:0]          kint,
    input logic [NDCO-1:0]          mid_code,
    input logic [NDCO-1:0]          ctrl_word,
    input logic signed [SUM_W-1:0]  wsum,
    input logic signed [STEP_W-1:0] int_step,
    input logic [NACC-1:0]          acc_q
);
    localparam logic [NACC-1:0] ACC_TOP = '1;

    logic signed [SUM_W-1:0] fwd_sum;

    always_comb begin
        fwd_sum = '0;
        for (int i = 0; i < 2; i++) begin
            fwd_sum = fwd_sum + SUM_W'($signed(err_vec[i*ERR_W +: ERR_W])
                                       * $signed({1'b0, wgt_vec[i*WGT_W +: WGT_W]}));
        end
    end

    // R1
    reset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ctrl_word == $past(mid_code));

    // R3
    startup_fwd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !coupled_en |-> wsum == fwd_sum);

    // R6
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kint) == '0) |-> acc_q == $past(acc_q));

    // R8
    acc_top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_q) == ACC_TOP && $past(int_step) >= 0) |-> acc_q == ACC_TOP);

    // R8
    acc_floor_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_q) == '0 && $past(int_step) <= 0) |-> acc_q == '0);

    // R7
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(kint) == '0 && $past(kprop) == '0
         && $past(kprop, 2) == '0) |-> $stable(ctrl_word));

endmodule

bind mesh_pi_filter mpf_filter_chk #(
    .NLINK (NLINK),
    .ERR_W (ERR_W),
    .WGT_W (WGT_W),
    .NDCO  (NDCO),
    .KP_W  (KP_W),
    .KI_W  (KI_W),
    .SUM_W (SUM_W),
    .NACC  (NACC),
    .STEP_W(STEP_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .coupled_en(coupled_en),
    .err_vec   (err_vec),
    .wgt_vec   (wgt_vec),
    .kprop     (kprop),
    .kint      (kint),
    .mid_code  (mid_code),
    .ctrl_word (ctrl_word),
    .wsum      (wsum),
    .int_step  (int_step),
    .acc_q     (acc_q)
);

// File: tb/mesh_pi_filter_tb_top.sv
module mesh_pi_filter_tb_top;
    localparam int NLINK = 4;
    localparam int ERR_W = 5;
    localparam int WGT_W = 4;
    localparam int NDCO  = 10;
    localparam int KP_W  = 6;
    localparam int KP_SH = 2;
    localparam int KI_W  = 6;
    localparam int KI_SH = 6;
    localparam longint ACC_LIM  = (longint'(1) << (NDCO + KI_SH)) - 1;
    localparam longint CTRL_LIM = (longint'(1) << NDCO) - 1;
    localparam logic [NDCO-1:0] MID = 10'd512;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   coupled_en = 1'b0;
    logic [NLINK*ERR_W-1:0] err_vec = '0;
    logic [NLINK*WGT_W-1:0] wgt_vec = '0;
    logic [KP_W-1:0]        kprop = '0;
    logic [KI_W-1:0]        kint = '0;
    logic [NDCO-1:0]        mid_code = MID;
    logic [NDCO-1:0]        ctrl_word;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        longint exp;
        string  tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    longint   acc_m;

    always #4 clk = ~clk;

    mesh_pi_filter #(
        .NLINK(NLINK), .ERR_W(ERR_W), .WGT_W(WGT_W), .NDCO(NDCO),
        .KP_W(KP_W), .KP_SH(KP_SH), .KI_W(KI_W), .KI_SH(KI_SH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .coupled_en(coupled_en),
        .err_vec(err_vec), .wgt_vec(wgt_vec), .kprop(kprop), .kint(kint),
        .mid_code(mid_code), .ctrl_word(ctrl_word)
    );

    task automatic check(input longint act, input longint exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: applies one sample and pushes the expected next control word
    task automatic drive(input int e0, input int e1, input int e2, input int e3,
                         input int w0, input int w1, input int w2, input int w3,
                         input bit cpl, input int kp, input int ki, input string tag);
        longint s, pr, ir, tot;
        @(negedge clk);
        err_vec    = {ERR_W'(e3), ERR_W'(e2), ERR_W'(e1), ERR_W'(e0)};
        wgt_vec    = {WGT_W'(w3), WGT_W'(w2), WGT_W'(w1), WGT_W'(w0)};
        coupled_en = cpl;
        kprop      = KP_W'(kp);
        kint       = KI_W'(ki);
        s = longint'(e0) * w0 + longint'(e1) * w1;
        if (cpl) s += longint'(e2) * w2 + longint'(e3) * w3;
        pr = (s * kp + (longint'(1) << (KP_SH - 1))) >>> KP_SH;
        acc_m = acc_m + s * ki;
        if (acc_m < 0) acc_m = 0;
        if (acc_m > ACC_LIM) acc_m = ACC_LIM;
        ir  = (acc_m + (longint'(1) << (KI_SH - 1))) >>> KI_SH;
        tot = ir + pr;
        if (tot < 0) tot = 0;
        if (tot > CTRL_LIM) tot = CTRL_LIM;
        sb_q.push_back('{exp: tot, tag: tag});
    endtask

    // monitor: compares each result one edge after its stimulus
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(longint'(ctrl_word), it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        acc_m = longint'(MID) << KI_SH;
        repeat (4) @(negedge clk);
        check(longint'(ctrl_word), 512, "R1 reset loads mid code");
        rst_n = 1'b1;
        @(negedge clk);
        check(longint'(ctrl_word), 512, "R1 idle after reset");

        // R7: zero errors keep the output at mid code
        drive(0, 0, 0, 0, 3, 3, 3, 3, 1, 4, 8, "R7 zero error");
        // R3: startup ignores lower/right; forward terms cancel
        drive(3, -2, 7, 7, 2, 3, 5, 5, 0, 4, 0, "R3 startup reverse links ignored");
        drive(3, -2, -15, 15, 2, 3, 5, 5, 0, 4, 0, "R3 startup reverse errors swapped");
        // R4: coupled mode adds lower/right
        drive(3, -2, 7, 7, 2, 3, 5, 5, 1, 4, 0, "R4 coupled all links");
        drive(1, 1, -3, 2, 1, 1, 4, 4, 1, 4, 0, "R4 coupled mixed signs");
        // R2: zero weight disconnects a link
        drive(0, 0, 0, 15, 0, 0, 0, 0, 1, 4, 0, "R2 zero weight positive err");
        drive(0, 0, 0, -16, 0, 0, 0, 0, 1, 4, 0, "R2 zero weight negative err");
        drive(-16, 15, 0, 0, 1, 1, 0, 0, 1, 4, 0, "R2 full-range errors");
        // R5: rounding with kprop=1 (x0.25)
        drive(2, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, "R5 +2/4 rounds to 1");
        drive(-2, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, "R5 -2/4 rounds to 0");
        drive(1, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, "R5 +1/4 rounds to 0");
        drive(-3, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, "R5 -3/4 rounds to -1");
        // R6: integration, step 32/64 per cycle
        for (int k = 0; k < 5; k++)
            drive(4, 0, 0, 0, 1, 0, 0, 0, 0, 0, 8, "R6 integrate positive");
        for (int k = 0; k < 3; k++)
            drive(-4, -4, 0, 0, 1, 1, 0, 0, 0, 0, 8, "R6 integrate negative");
        // R8/R9: drive accumulator to top and back
        for (int k = 0; k < 4; k++)
            drive(15, 15, 15, 15, 15, 15, 15, 15, 1, 63, 63, "R8 top saturation");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 output at top");
        drive(-16, -16, 0, 0, 15, 15, 0, 0, 0, 0, 63, "R8 leave top at once");
        for (int k = 0; k < 4; k++)
            drive(-16, -16, -16, -16, 15, 15, 15, 15, 1, 63, 63, "R8 floor saturation");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R9 output at floor");
        drive(1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 63, "R8 leave floor at once");
        drive(15, 15, 15, 15, 15, 15, 15, 15, 1, 63, 0, "R9 proportional clamp high");
        drive(-16, -16, -16, -16, 15, 15, 15, 15, 1, 63, 0, "R9 proportional clamp low");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule